// File: doc/BRIEF.md
# Bit-Oriented Frame Transmitter with Underrun Closing

This block drives one synchronous serial line with bit-stuffed frames. A host places one octet at a time into a single holding register. The block moves each octet into a shift register and sends it least significant bit first, inserting a 0 after every run of five 1s. While a frame is open it accumulates a 16-bit frame check sequence. Between frames the line carries continuous 0x7E flags, or steady 1s (marks) while the transmit enable is low.

Frames close without host help. If the holding register is empty when an octet finishes and the end-of-message latch has been cleared by the host (armed), the block appends the complemented check sequence and then a flag. It sets the latch and raises a one-cycle status interrupt. If the latch is still set, an underrun just closes the frame with a flag. The host can tell a real end of message from a late refill. A byte written during the check-sequence fill goes into the next frame. A frame can be cancelled with an abort, which sends eight 1s.

The line advances one bit per `bit_en` strobe.

Top module: `sdlc_underrun_tx`

## Requirements
- R1: With `tx_enable` high and no frame open, the line carries back-to-back flags 0x7E.
- R2: Frame octets are sent LSB first. After five consecutive 1s of data or check sequence, a 0 is inserted. Flags, marks and the abort pattern get no inserted 0s.
- R3: On an underrun with `eom_latch` low (armed), the block sends the check sequence and then a flag. The check sequence is x^16+x^12+x^5+1, preset to all ones, updated LSB first over the frame's data, complemented, and sent low octet first.
- R4: An armed underrun sets `eom_latch` and pulses `ext_irq` for exactly one clock. `eom_latch` never rises without that pulse.
- R5: An underrun with `eom_latch` high closes the frame with a flag only. No check sequence is sent and `ext_irq` does not pulse.
- R6: `eom_latch` is 1 after reset. A one-cycle `cmd_arm` clears it on the next clock edge.
- R7: `tbe_irq` pulses once for each octet taken from the holding register. It pulses once more when the closing flag after a check sequence is loaded and the holding register is empty.
- R8: An octet written while the check sequence is being sent starts a new frame after the closing flag.
- R9: `cmd_abort` while a frame or its check sequence is being sent makes the block send eight 1s at the next octet boundary, then return to flags, and the frame is discarded. `cmd_abort` with no frame open has no effect.
- R10: A write while `buf_empty` is low is ignored.
- R11: While `tx_enable` is low and no frame is open, the line stays at 1 and no octet is taken from the holding register.
- R12: During reset, `txd` is 1, `buf_empty` is 1, `eom_latch` is 1, and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe that advances the line by one bit |
| tx_enable | input | 1 | Allows new frames to start; marks are sent when low and idle |
| wr_valid | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Octet to transmit |
| cmd_arm | input | 1 | Clears the end-of-message latch |
| cmd_abort | input | 1 | Requests abort of the open frame |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register can accept an octet |
| eom_latch | output | 1 | End-of-message / underrun latch |
| tbe_irq | output | 1 | One-cycle pulse: holding register emptied, or frame closed after check sequence |
| ext_irq | output | 1 | One-cycle pulse: armed underrun occurred |

## Verification
The properties assume that `bit_en` is a single-cycle strobe with at least one idle clock between strobes. They also assume that `cmd_arm` and `cmd_abort` are one-cycle pulses. The stimulus makes `bit_en` one clock in every four and drives every command for exactly one clock.

Writes wait for `buf_empty`, except for the one deliberate write into a full register. Each arm follows within a few clocks of the first octet being taken. This keeps underruns only where the test intends them.

The line is decoded by an independent bit-level receiver that removes inserted 0s. It compares each frame against an expected queue whose check values are computed in the bench.

// File: rtl/sdlc_tx_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the bit-stuffed frame transmitter.
// Assumes octet-wide items on the line; the flag and abort patterns are fixed by protocol.
package sdlc_tx_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FLAG_OCTET = 8'h7E;
    localparam logic [BYTE_W-1:0] ONES_OCTET = 8'hFF;

    // What the shift register is currently carrying.
    typedef enum logic [2:0] {
        K_MARK  = 3'd0,
        K_FLAG  = 3'd1,
        K_DATA  = 3'd2,
        K_FCS   = 3'd3,
        K_ABORT = 3'd4
    } item_kind_t;

    // Framing state as seen at octet boundaries.
    typedef enum logic [1:0] {
        F_IDLE   = 2'd0,
        F_DATA   = 2'd1,
        F_FCS_LO = 2'd2,
        F_FCS_HI = 2'd3
    } frame_st_t;

    // Only frame content is subject to zero insertion.
    function automatic logic is_stuffable(item_kind_t k);
        return (k == K_DATA) || (k == K_FCS);
    endfunction
endpackage

// File: rtl/sdlc_tx_holdreg.sv
`timescale 1ns/1ps
// Single-octet holding register between the host and the shift register.
// Assumes take is only asserted while full; writes while full are dropped.
module sdlc_tx_holdreg
    import sdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [BYTE_W-1:0] data
);
    // Capture a host octet when empty; release it when the shifter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_valid && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end
endmodule

// File: rtl/sdlc_fcs_gen.sv
`timescale 1ns/1ps
// Bit-serial frame check sequence generator, reflected (LSB-first) form.
// Assumes init and bit_valid never coincide; crc_upd is the value after the current bit.
module sdlc_fcs_gen #(
    parameter int               CRC_W    = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
    parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_upd
);
    // Next remainder if the present line bit is a data bit.
    always_comb begin
        crc_upd = {1'b0, crc_q[CRC_W-1:1]} ^ ((crc_q[0] ^ bit_in) ? CRC_POLY : '0);
    end

    // Preset at frame start, advance on every data bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         crc_q <= CRC_INIT;
        else if (init)      crc_q <= CRC_INIT;
        else if (bit_valid) crc_q <= crc_upd;
    end
endmodule

// File: rtl/sdlc_bit_serializer.sv
`timescale 1ns/1ps
// Shifts one octet item onto the line per eight strobes, LSB first, inserting a 0
// after STUFF_RUN consecutive 1s of stuffable content. Loads the next item
// presented by the controller on the strobe that sends the last bit.
// Assumes nxt_kind/nxt_octet are valid whenever item_last is high.
module sdlc_bit_serializer
    import sdlc_tx_pkg::*;
#(
    parameter int STUFF_RUN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  item_kind_t        nxt_kind,
    input  logic [BYTE_W-1:0] nxt_octet,
    output logic              txd,
    output logic              item_last,
    output item_kind_t        cur_kind,
    output logic              data_bit_valid,
    output logic              data_bit
);
    localparam int CW = $clog2(BYTE_W);
    localparam int OW = $clog2(STUFF_RUN + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh_q;
    logic [CW-1:0]     cnt_q;
    logic [OW-1:0]     ones_q;
    logic              stuff_now;

    // Decode the per-strobe actions.
    always_comb begin
        stuff_now      = (ones_q == OW'(STUFF_RUN));
        item_last      = bit_en && !stuff_now && (cnt_q == LAST_IDX);
        data_bit       = sh_q[0];
        data_bit_valid = bit_en && !stuff_now && (cur_kind == K_DATA);
    end

    // Drive the line, count 1s, and step through the item.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd      <= 1'b1;
            sh_q     <= ONES_OCTET;
            cur_kind <= K_MARK;
            cnt_q    <= '0;
            ones_q   <= '0;
        end else if (bit_en) begin
            if (stuff_now) begin
                txd    <= 1'b0;
                ones_q <= '0;
            end else begin
                txd    <= sh_q[0];
                ones_q <= (is_stuffable(cur_kind) && sh_q[0]) ? ones_q + OW'(1) : '0;
                if (cnt_q == LAST_IDX) begin
                    sh_q     <= nxt_octet;
                    cur_kind <= nxt_kind;
                    cnt_q    <= '0;
                end else begin
                    sh_q  <= sh_q >> 1;
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sdlc_frame_ctl.sv
`timescale 1ns/1ps
// Frame sequencer: chooses the next item at every octet boundary, runs the
// underrun closing (check sequence or bare flag), the end-of-message latch,
// abort handling and both interrupt pulses.
// Assumes item_last is a single-cycle pulse and commands are single-cycle.
module sdlc_frame_ctl
    import sdlc_tx_pkg::*;
#(
    parameter int CRC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              item_last,
    input  item_kind_t        cur_kind,
    input  logic              tx_enable,
    input  logic              buf_full,
    input  logic [BYTE_W-1:0] buf_data,
    input  logic [CRC_W-1:0]  crc_q,
    input  logic [CRC_W-1:0]  crc_upd,
    input  logic              cmd_arm,
    input  logic              cmd_abort,
    output item_kind_t        nxt_kind,
    output logic [BYTE_W-1:0] nxt_octet,
    output logic              buf_take,
    output logic              crc_init,
    output logic              eom_latch,
    output logic              ext_irq,
    output logic              tbe_irq
);
    frame_st_t st_q, st_d;
    logic      abort_q;
    logic      take_c, init_c, underrun_c, tbe_c, abort_go;

    // Select the next item and framing state for the coming boundary.
    always_comb begin
        st_d       = st_q;
        nxt_kind   = K_FLAG;
        nxt_octet  = FLAG_OCTET;
        take_c     = 1'b0;
        init_c     = 1'b0;
        underrun_c = 1'b0;
        tbe_c      = 1'b0;
        abort_go   = 1'b0;
        if (abort_q && st_q != F_IDLE) begin
            nxt_kind  = K_ABORT;
            nxt_octet = ONES_OCTET;
            st_d      = F_IDLE;
            abort_go  = 1'b1;
        end else begin
            case (st_q)
                F_IDLE: begin
                    if (!tx_enable) begin
                        nxt_kind  = K_MARK;
                        nxt_octet = ONES_OCTET;
                    end else if (buf_full && cur_kind == K_FLAG) begin
                        nxt_kind  = K_DATA;
                        nxt_octet = buf_data;
                        take_c    = 1'b1;
                        init_c    = 1'b1;
                        tbe_c     = 1'b1;
                        st_d      = F_DATA;
                    end
                end
                F_DATA: begin
                    if (buf_full) begin
                        nxt_kind  = K_DATA;
                        nxt_octet = buf_data;
                        take_c    = 1'b1;
                        tbe_c     = 1'b1;
                    end else if (!eom_latch) begin
                        nxt_kind   = K_FCS;
                        nxt_octet  = ~crc_upd[BYTE_W-1:0];
                        underrun_c = 1'b1;
                        st_d       = F_FCS_LO;
                    end else begin
                        st_d = F_IDLE;
                    end
                end
                F_FCS_LO: begin
                    nxt_kind  = K_FCS;
                    nxt_octet = ~crc_q[2*BYTE_W-1:BYTE_W];
                    st_d      = F_FCS_HI;
                end
                default: begin
                    tbe_c = !buf_full;
                    st_d  = F_IDLE;
                end
            endcase
        end
        buf_take = item_last && take_c;
        crc_init = item_last && init_c;
    end

    // Advance the framing state at octet boundaries only.
    always_ff @(posedge clk) begin
        if (!rst_n)         st_q <= F_IDLE;
        else if (item_last) st_q <= st_d;
    end

    // Underrun latch: set by an armed underrun, cleared by the host command.
    always_ff @(posedge clk) begin
        if (!rst_n)                        eom_latch <= 1'b1;
        else if (item_last && underrun_c)  eom_latch <= 1'b1;
        else if (cmd_arm)                  eom_latch <= 1'b0;
    end

    // One-cycle interrupt pulses at the boundary that caused them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_irq <= 1'b0;
            tbe_irq <= 1'b0;
        end else begin
            ext_irq <= item_last && underrun_c;
            tbe_irq <= item_last && tbe_c;
        end
    end

    // Hold an abort request until the next boundary of an open frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   abort_q <= 1'b0;
        else if (st_q == F_IDLE || (item_last && abort_go)) abort_q <= 1'b0;
        else if (cmd_abort)                           abort_q <= 1'b1;
    end
endmodule

// File: rtl/sdlc_underrun_tx.sv
`timescale 1ns/1ps
// Top: bit-stuffed frame transmitter with automatic underrun closing.
// Assumes bit_en strobes are single-cycle and separated by at least one idle clock.
module sdlc_underrun_tx
    import sdlc_tx_pkg::*;
#(
    parameter int          STUFF_RUN = 5,
    parameter logic [15:0] CRC_POLY  = 16'h8408,
    parameter logic [15:0] CRC_INIT  = 16'hFFFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       tx_enable,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       cmd_arm,
    input  logic       cmd_abort,
    output logic       txd,
    output logic       buf_empty,
    output logic       eom_latch,
    output logic       tbe_irq,
    output logic       ext_irq
);
    localparam int CRC_W = 16;

    logic              buf_full, buf_take, crc_init;
    logic [BYTE_W-1:0] buf_data, nxt_octet;
    logic [CRC_W-1:0]  crc_q, crc_upd;
    logic              item_last, data_bit_valid, data_bit;
    item_kind_t        cur_kind, nxt_kind;

    assign buf_empty = !buf_full;

    sdlc_tx_holdreg u_hold (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .take(buf_take), .full(buf_full), .data(buf_data)
    );

    sdlc_fcs_gen #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) u_fcs (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .bit_valid(data_bit_valid),
        .bit_in(data_bit), .crc_q(crc_q), .crc_upd(crc_upd)
    );

    sdlc_bit_serializer #(.STUFF_RUN(STUFF_RUN)) u_ser (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .nxt_kind(nxt_kind),
        .nxt_octet(nxt_octet), .txd(txd), .item_last(item_last),
        .cur_kind(cur_kind), .data_bit_valid(data_bit_valid), .data_bit(data_bit)
    );

    sdlc_frame_ctl #(.CRC_W(CRC_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .item_last(item_last), .cur_kind(cur_kind),
        .tx_enable(tx_enable), .buf_full(buf_full), .buf_data(buf_data),
        .crc_q(crc_q), .crc_upd(crc_upd), .cmd_arm(cmd_arm), .cmd_abort(cmd_abort),
        .nxt_kind(nxt_kind), .nxt_octet(nxt_octet), .buf_take(buf_take),
        .crc_init(crc_init), .eom_latch(eom_latch), .ext_irq(ext_irq), .tbe_irq(tbe_irq)
    );
endmodule

// File: rtl/sdlc_underrun_tx_chk.sv
`timescale 1ns/1ps
// Port-level property checker for sdlc_underrun_tx, attached by bind.
// Assumes single-cycle bit_en strobes and single-cycle commands.
module sdlc_underrun_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic cmd_arm,
    input logic txd,
    input logic buf_empty,
    input logic eom_latch,
    input logic tbe_irq,
    input logic ext_irq
);
    a_r4_irq_with_latch_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> (eom_latch && !$past(eom_latch)));

    a_r4_latch_rise_has_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eom_latch) |-> ext_irq);

    a_r6_arm_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_arm && !bit_en) |=> !eom_latch);

    a_r2_line_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(txd));

    a_r7_tbe_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        tbe_irq |-> $past(bit_en));

    a_r4_ext_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |=> !ext_irq);

    a_r10_full_held_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_empty && !bit_en) |=> !buf_empty);
endmodule

bind sdlc_underrun_tx sdlc_underrun_tx_chk i_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cmd_arm(cmd_arm), .txd(txd),
    .buf_empty(buf_empty), .eom_latch(eom_latch), .tbe_irq(tbe_irq), .ext_irq(ext_irq)
);

// File: tb/test_sdlc_underrun_tx.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks queue expected frames, a line receiver decodes txd and compares.
module test_sdlc_underrun_tx;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0, bit_en = 1'b0, tx_enable = 1'b1, wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cmd_arm = 1'b0, cmd_abort = 1'b0;
    logic       txd, buf_empty, eom_latch, tbe_irq, ext_irq;

    sdlc_underrun_tx i_sdlc_underrun_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
        .wr_valid(wr_valid), .wr_data(wr_data), .cmd_arm(cmd_arm), .cmd_abort(cmd_abort),
        .txd(txd), .buf_empty(buf_empty), .eom_latch(eom_latch),
        .tbe_irq(tbe_irq), .ext_irq(ext_irq)
    );

    int checks = 0, errors = 0;
    int tick_div = 0;
    int ones = 0, flag_cnt = 0, abort_cnt = 0, zero_cnt = 0, frames_rx = 0;
    int ext_cnt = 0, tbe_cnt = 0;
    bit hunting = 1'b1;
    bit rx_bits[$];
    logic [7:0] exp_bytes[$];
    int exp_len[$];
    logic [7:0] frm[$];

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Compare a received frame of len bits with the next expected frame.
    task automatic emit(input int len);
        int nb, el;
        logic [7:0] b;
        if (len <= 0) return;
        frames_rx++;
        chk(len % 8 == 0, "R2 frame octet alignment", len, (len / 8) * 8);
        if (len % 8 != 0) return;
        nb = len / 8;
        if (exp_len.size() == 0) begin
            chk(1'b0, "R9 unexpected frame octets", nb, 0);
            return;
        end
        el = exp_len.pop_front();
        chk(nb == el, "R3 frame length", nb, el);
        for (int i = 0; i < el; i++) begin
            logic [7:0] e;
            e = exp_bytes.pop_front();
            if (i < nb) begin
                for (int k = 0; k < 8; k++) b[k] = rx_bits[i * 8 + k];
                chk(b == e, "R2 R3 frame octet", b, e);
            end
        end
    endtask

    // Receiver: removes inserted zeros, finds flags and aborts.
    task automatic mon_bit(input logic v);
        if (v) begin
            ones++;
            rx_bits.push_back(1'b1);
            if (ones == 7 && !hunting) begin
                if (rx_bits.size() > 7) abort_cnt++;
                hunting = 1'b1;
            end
            if (ones >= 7) rx_bits.delete();
        end else begin
            zero_cnt++;
            if (ones >= 7) begin
                hunting = 1'b0;
                rx_bits.delete();
                rx_bits.push_back(1'b0);
            end else if (ones == 6) begin
                flag_cnt++;
                if (!hunting) emit(rx_bits.size() - 7);
                rx_bits.delete();
                hunting = 1'b0;
            end else if (ones == 5 && !hunting) begin
                // inserted zero, dropped
            end else begin
                rx_bits.push_back(1'b0);
            end
            ones = 0;
        end
    endtask

    // Strobe generator and line sampling after the strobed edge.
    always @(negedge clk) begin
        if (rst_n && bit_en) mon_bit(txd);
        if (rst_n && ext_irq) ext_cnt++;
        if (rst_n && tbe_irq) tbe_cnt++;
        tick_div = (tick_div == 3) ? 0 : tick_div + 1;
        bit_en = (tick_div == 0);
    end

    function automatic logic [15:0] fcs_of(input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[0] ^ frm[i][k];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        return ~c;
    endfunction

    task automatic expect_frame(input bit with_fcs);
        logic [15:0] f;
        f = fcs_of(frm.size());
        foreach (frm[i]) exp_bytes.push_back(frm[i]);
        if (with_fcs) begin
            exp_bytes.push_back(f[7:0]);
            exp_bytes.push_back(f[15:8]);
        end
        exp_len.push_back(frm.size() + (with_fcs ? 2 : 0));
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] b);
        @(negedge clk);
        while (!buf_empty) @(negedge clk);
        wr_valid = 1'b1; wr_data = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_arm();
        cmd_arm = 1'b1;
        @(negedge clk);
        cmd_arm = 1'b0;
        chk(eom_latch == 1'b0, "R6 arm clears latch", eom_latch, 0);
    endtask

    task automatic send_armed();
        host_write(frm[0]);
        while (!buf_empty) @(negedge clk);
        pulse_arm();
        for (int i = 1; i < frm.size(); i++) host_write(frm[i]);
    endtask

    task automatic wait_frames(input int n);
        while (frames_rx < n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        int e0, t0, a0, f0, z0;
        repeat (6) @(negedge clk);
        // R12 reset state
        chk(txd == 1'b1, "R12 txd in reset", txd, 1);
        chk(buf_empty == 1'b1, "R12 buf_empty in reset", buf_empty, 1);
        chk(eom_latch == 1'b1, "R12 R6 latch in reset", eom_latch, 1);
        chk(!ext_irq && !tbe_irq, "R12 irqs in reset", {ext_irq, tbe_irq}, 0);
        rst_n = 1'b1;

        // R1 idle flags
        wait_ticks(40);
        chk(flag_cnt >= 3, "R1 idle flags", flag_cnt, 3);
        chk(abort_cnt == 0, "R1 no abort in idle", abort_cnt, 0);

        // R2 R3 R4 R7 armed frame with stuffing-heavy content
        frm = '{8'hA5, 8'hFF, 8'h7E, 8'h3E};
        expect_frame(1'b1);
        e0 = ext_cnt; t0 = tbe_cnt;
        send_armed();
        wait_frames(1);
        wait_ticks(4);
        chk(ext_cnt - e0 == 1, "R4 one ext_irq per armed underrun", ext_cnt - e0, 1);
        chk(tbe_cnt - t0 == 5, "R7 tbe pulses", tbe_cnt - t0, 5);
        chk(eom_latch == 1'b1, "R4 latch set after underrun", eom_latch, 1);

        // R8 late refill during check sequence, R5 unarmed underrun
        frm = '{8'h12, 8'h34};
        expect_frame(1'b1);
        frm = '{8'h5A};
        expect_frame(1'b0);
        frm = '{8'h12, 8'h34};
        e0 = ext_cnt;
        send_armed();
        while (ext_cnt == e0) @(negedge clk);
        host_write(8'h5A);
        wait_frames(3);
        wait_ticks(4);
        chk(ext_cnt - e0 == 1, "R5 no second ext_irq", ext_cnt - e0, 1);
        chk(eom_latch == 1'b1, "R5 latch stays set", eom_latch, 1);

        // R11 enable low: marks, no take; R10 write while full ignored
        tx_enable = 1'b0;
        wait_ticks(24);
        z0 = zero_cnt;
        @(negedge clk);
        wr_valid = 1'b1; wr_data = 8'h11;
        @(negedge clk);
        wr_data = 8'h22;
        @(negedge clk);
        wr_valid = 1'b0;
        wait_ticks(16);
        chk(zero_cnt == z0, "R11 line held at 1", zero_cnt - z0, 0);
        chk(buf_empty == 1'b0, "R11 octet not taken", buf_empty, 0);
        frm = '{8'h11};
        expect_frame(1'b1);
        tx_enable = 1'b1;
        while (!buf_empty) @(negedge clk);
        pulse_arm();
        chk(buf_empty == 1'b1, "R10 dropped write not held", buf_empty, 1);
        wait_frames(4);

        // R9 abort ignored while idle
        wait_ticks(8);
        a0 = abort_cnt; f0 = flag_cnt;
        @(negedge clk); cmd_abort = 1'b1;
        @(negedge clk); cmd_abort = 1'b0;
        wait_ticks(30);
        chk(abort_cnt == a0, "R9 idle abort ignored", abort_cnt, a0);
        chk(flag_cnt > f0, "R1 R9 flags continue", flag_cnt, f0 + 1);

        // R9 abort during check-sequence fill
        e0 = ext_cnt;
        host_write(8'h99);
        while (!buf_empty) @(negedge clk);
        pulse_arm();
        while (ext_cnt == e0) @(negedge clk);
        cmd_abort = 1'b1;
        @(negedge clk); cmd_abort = 1'b0;
        wait_ticks(40);
        chk(abort_cnt == a0 + 1, "R9 abort sent", abort_cnt, a0 + 1);
        chk(frames_rx == 4, "R9 aborted frame discarded", frames_rx, 4);
        chk(exp_len.size() == 0, "R3 all expected frames seen", exp_len.size(), 0);

        summary();
        $finish;
    end
endmodule